// File: doc/BRIEF.md
# Predicated Vector CR Field Writer

This block applies the integer-to-condition-field masked operation across a run of consecutive 4-bit condition fields, one field per clock. A command gives a base field index, an element count, a 64-bit destination predicate, a zeroing enable, a merge bit, a 4-bit mask and a 4-bit mode. It also gives one integer source bit per element. Element `i` lands in field `(base + i)` modulo the number of fields. The block holds the condition fields itself and exposes a read port so that their contents can be observed.

For each element, the destination predicate and the zeroing enable choose one of three outcomes. The field can receive the computed masked-equality result. It can be cleared to all zeros. Or it can be left alone. A flag marking the source register as the zero register forces every source bit to zero. In that case the predicate itself is what gets copied into the fields.

Top module: `crw_vec_writer`

## Requirements
- R1: After reset, every condition field reads 0000, and `busy` and `done` are low.
- R2: Element `i` is written to field `(base_idx + i) mod NUM_FIELDS`. Elements are taken in increasing order, one per clock, so a run that passes the last field continues at field 0.
- R3: If predicate bit `i` is 1 and `merge_m` is 0, the field becomes `mask & ~(mode ^ {4{s}})`, where `s` is the element's source bit. In other words, field bit j is 1 exactly when mask bit j is 1 and mode bit j equals `s`.
- R4: If predicate bit `i` is 1 and `merge_m` is 1, the bits where mask is 1 follow R3, and the bits where mask is 0 keep their previous value.
- R5: If predicate bit `i` is 0 and `zero_en` is 1, the field becomes 0000, whatever the source, mode or merge bit.
- R6: If predicate bit `i` is 0 and `zero_en` is 0, the field is left unchanged.
- R7: When `src_zero` is 1, every element uses `s = 0` regardless of `src_bits`. With mask 0011 and mode 0000, an enabled element then reads 0011.
- R8: `busy` is high for exactly `vec_len` cycles after an accepted `start`. `done` pulses high for one cycle immediately afterwards. A `vec_len` of 0 gives `done` on the cycle after `start` with no field written. Values above 64 are treated as 64.
- R9: A `start` that arrives while `busy` is high is ignored, together with all the operands presented with it.
- R10: Fields outside the range addressed by the command keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a command (accepted only when idle) |
| base_idx | input | 6 | First target field |
| vec_len | input | 7 | Element count, 0 to 64 |
| dst_pred | input | 64 | Destination predicate, bit i for element i |
| zero_en | input | 1 | Zero the fields of disabled elements |
| merge_m | input | 1 | Keep the old field bits where mask is 0 |
| mask | input | 4 | Field bit select |
| mode | input | 4 | Expected value per field bit |
| src_zero | input | 1 | Source is the zero register; forces the source bits to 0 |
| src_bits | input | 64 | Integer source bit, bit i for element i |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_idx | input | 6 | Field read address |
| rd_field | output | 4 | Contents of field `rd_idx` |

## Verification
The bench first fills every field with a nonzero pattern, so that zeroing, skipping and merging can each be told apart. A design that ignored zeroing would leave stale nibbles behind. One that merged when `merge_m` is 0 would leak old bits. One that wrote skipped elements would corrupt fields that should have been held. A run starting at field 62 checks the wrap: a design that failed to wrap would scribble past the end or miss fields 0 and 1. A zero-length command checks that `done` still pulses. A second `start` issued mid-run must not alter the first command's operands or its cycle count.

// File: rtl/crw_pkg.sv
package crw_pkg;
  localparam int FW = 4;
  typedef logic [FW-1:0] field_t;

  // bit j set when mask selects it and mode bit matches the source bit
  function automatic field_t crw_hit(field_t msk, field_t mde, logic s);
    return msk & ~(mde ^ {FW{s}});
  endfunction

  // optionally keep old bits outside the mask
  function automatic field_t crw_merge(field_t hit, field_t old, field_t msk, logic m);
    return m ? (hit | (old & ~msk)) : hit;
  endfunction
endpackage

// File: rtl/crw_seq.sv
module crw_seq #(
  parameter int PRED_W = 64,
  parameter int IDX_W  = 6,
  parameter int VL_W   = $clog2(PRED_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [VL_W-1:0]   vec_len,
  input  logic [PRED_W-1:0] dst_pred,
  input  logic              zero_en,
  input  logic              merge_m,
  input  crw_pkg::field_t   mask,
  input  crw_pkg::field_t   mode,
  input  logic              src_zero,
  input  logic [PRED_W-1:0] src_bits,
  output logic              busy,
  output logic              done,
  output logic              el_go,
  output logic [IDX_W-1:0]  el_idx,
  output logic              el_pred,
  output logic              el_src,
  output logic              cfg_zen,
  output logic              cfg_m,
  output crw_pkg::field_t   cfg_mask,
  output crw_pkg::field_t   cfg_mode
);
  localparam int EW = (PRED_W > 1) ? $clog2(PRED_W) : 1;
  localparam logic [VL_W-1:0] VL_MAX = VL_W'(PRED_W);

  logic [IDX_W-1:0]  base_q;
  logic [VL_W-1:0]   vl_q;
  logic [PRED_W-1:0] pred_q;
  logic [PRED_W-1:0] src_q;
  logic [EW-1:0]     cnt;
  logic [VL_W-1:0]   vl_eff;
  logic              accept;
  logic              last_el;

  assign vl_eff  = (vec_len > VL_MAX) ? VL_MAX : vec_len;
  assign accept  = start && !busy;
  assign last_el = busy && ((VL_W'(cnt) + VL_W'(1)) == vl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cnt      <= '0;
      base_q   <= '0;
      vl_q     <= '0;
      pred_q   <= '0;
      src_q    <= '0;
      cfg_zen  <= 1'b0;
      cfg_m    <= 1'b0;
      cfg_mask <= '0;
      cfg_mode <= '0;
    end else begin
      done <= last_el || (accept && vl_eff == '0);
      if (accept) begin
        busy     <= (vl_eff != '0);
        cnt      <= '0;
        base_q   <= base_idx;
        vl_q     <= vl_eff;
        pred_q   <= dst_pred;
        src_q    <= src_zero ? '0 : src_bits;
        cfg_zen  <= zero_en;
        cfg_m    <= merge_m;
        cfg_mask <= mask;
        cfg_mode <= mode;
      end else if (busy) begin
        if (last_el) busy <= 1'b0;
        cnt <= cnt + EW'(1);
      end
    end
  end

  assign el_go   = busy;
  assign el_idx  = base_q + IDX_W'(cnt);
  assign el_pred = pred_q[cnt];
  assign el_src  = src_q[cnt];

  // R8
  done_excl_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (VL_W'(cnt) < vl_q));
  // R9
  cfg_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_el) |=> (busy && $stable(cfg_mask) && $stable(base_q) && $stable(cfg_m)));
endmodule

// File: rtl/crw_elem_alu.sv
module crw_elem_alu (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            pred,
  input  logic            s,
  input  logic            zen,
  input  logic            m,
  input  crw_pkg::field_t mask,
  input  crw_pkg::field_t mode,
  input  crw_pkg::field_t old,
  output logic            we,
  output crw_pkg::field_t val
);
  import crw_pkg::*;

  field_t hit;
  assign hit = crw_hit(mask, mode, s);

  always_comb begin
    we  = 1'b0;
    val = old;
    if (go) begin
      if (pred) begin
        we  = 1'b1;
        val = crw_merge(hit, old, mask, m);
      end else if (zen) begin
        we  = 1'b1;
        val = '0;
      end
    end
  end

  // R6
  skip_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !pred && !zen) |-> !we);
  // R5
  zeroed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !pred) |-> (val == '0));
  // R4
  merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && pred && m) |-> ((val & ~mask) == (old & ~mask)));
endmodule

// File: rtl/crw_field_file.sv
module crw_field_file #(
  parameter int NUM_FIELDS = 64,
  parameter int IDX_W      = $clog2(NUM_FIELDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  crw_pkg::field_t  wr_val,
  output crw_pkg::field_t  old_val,
  input  logic [IDX_W-1:0] rd_idx,
  output crw_pkg::field_t  rd_val
);
  crw_pkg::field_t        fld [NUM_FIELDS];
  logic [NUM_FIELDS-1:0]  wr_hit;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    assign wr_hit[g] = we && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)         fld[g] <= '0;
      else if (wr_hit[g]) fld[g] <= wr_val;
    end
  end

  assign old_val = fld[wr_idx];
  assign rd_val  = fld[rd_idx];

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));
  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (fld[$past(wr_idx)] == $past(wr_val)));
endmodule

// File: rtl/crw_vec_writer.sv
module crw_vec_writer #(
  parameter int NUM_FIELDS = 64,
  parameter int PRED_W     = 64,
  parameter int IDX_W      = $clog2(NUM_FIELDS),
  parameter int VL_W       = $clog2(PRED_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [VL_W-1:0]   vec_len,
  input  logic [PRED_W-1:0] dst_pred,
  input  logic              zero_en,
  input  logic              merge_m,
  input  logic [3:0]        mask,
  input  logic [3:0]        mode,
  input  logic              src_zero,
  input  logic [PRED_W-1:0] src_bits,
  output logic              busy,
  output logic              done,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [3:0]        rd_field
);
  import crw_pkg::*;

  logic             el_go, el_pred, el_src, cfg_zen, cfg_m, wr_en;
  logic [IDX_W-1:0] el_idx;
  field_t           cfg_mask, cfg_mode, old_val, wr_val;

  crw_seq #(.PRED_W(PRED_W), .IDX_W(IDX_W), .VL_W(VL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base_idx(base_idx),
    .vec_len(vec_len), .dst_pred(dst_pred), .zero_en(zero_en),
    .merge_m(merge_m), .mask(mask), .mode(mode), .src_zero(src_zero),
    .src_bits(src_bits), .busy(busy), .done(done), .el_go(el_go),
    .el_idx(el_idx), .el_pred(el_pred), .el_src(el_src),
    .cfg_zen(cfg_zen), .cfg_m(cfg_m), .cfg_mask(cfg_mask), .cfg_mode(cfg_mode)
  );

  crw_elem_alu u_alu (
    .clk(clk), .rst_n(rst_n), .go(el_go), .pred(el_pred), .s(el_src),
    .zen(cfg_zen), .m(cfg_m), .mask(cfg_mask), .mode(cfg_mode),
    .old(old_val), .we(wr_en), .val(wr_val)
  );

  crw_field_file #(.NUM_FIELDS(NUM_FIELDS), .IDX_W(IDX_W)) u_file (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .wr_idx(el_idx), .wr_val(wr_val),
    .old_val(old_val), .rd_idx(rd_idx), .rd_val(rd_field)
  );

  // R10
  write_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);
endmodule

// File: tb/crw_vec_writer_tb.sv
module crw_vec_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  base_idx = '0;
  logic [6:0]  vec_len = '0;
  logic [63:0] dst_pred = '0;
  logic        zero_en = 1'b0;
  logic        merge_m = 1'b0;
  logic [3:0]  mask = '0;
  logic [3:0]  mode = '0;
  logic        src_zero = 1'b0;
  logic [63:0] src_bits = '0;
  logic        busy, done;
  logic [5:0]  rd_idx = '0;
  logic [3:0]  rd_field;

  int errors = 0;
  int checks = 0;
  logic [3:0] model [NF];

  always #(CLK_PERIOD/2) clk = ~clk;

  crw_vec_writer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_idx(base_idx),
    .vec_len(vec_len), .dst_pred(dst_pred), .zero_en(zero_en),
    .merge_m(merge_m), .mask(mask), .mode(mode), .src_zero(src_zero),
    .src_bits(src_bits), .busy(busy), .done(done), .rd_idx(rd_idx),
    .rd_field(rd_field)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench's own restatement of the per-element rule
  task automatic model_apply(input int base, input int vl, input logic [63:0] pred,
                             input bit zen, input bit m, input logic [3:0] mk,
                             input logic [3:0] md, input bit sz, input logic [63:0] src);
    for (int i = 0; i < vl; i++) begin
      int idx = (base + i) % NF;
      bit s = sz ? 1'b0 : src[i];
      for (int b = 0; b < 4; b++) begin
        if (pred[i]) begin
          if (mk[b]) model[idx][b] = (md[b] == s);
          else if (!m) model[idx][b] = 1'b0;
        end else if (zen) begin
          model[idx][b] = 1'b0;
        end
      end
    end
  endtask

  task automatic compare_all(input string req);
    int bad = 0;
    for (int f = 0; f < NF; f++) begin
      rd_idx = 6'(f);
      #1;
      if (rd_field !== model[f]) begin
        bad++;
        $display("FAIL %s field %0d actual=%0h expected=%0h", req, f, rd_field, model[f]);
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic run_op(input string req, input int base, input int vl,
                        input logic [63:0] pred, input bit zen, input bit m,
                        input logic [3:0] mk, input logic [3:0] md, input bit sz,
                        input logic [63:0] src, input bit intrude);
    int cycles = 0;
    int guard = 0;
    @(negedge clk);
    base_idx = 6'(base); vec_len = 7'(vl); dst_pred = pred; zero_en = zen;
    merge_m = m; mask = mk; mode = md; src_zero = sz; src_bits = src;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 200) begin
      if (busy) cycles++;
      if (intrude && cycles == 1) begin
        start = 1'b1; mask = ~mk; mode = ~md; base_idx = 6'(base + 20);
        dst_pred = ~pred; merge_m = ~m; vec_len = 7'd64;
      end else begin
        start = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    model_apply(base, (vl > 64) ? 64 : vl, pred, zen, m, mk, md, sz, src);
    check(cycles == ((vl > 64) ? 64 : vl), {req, " R8 busy cycles"}, cycles, vl);
    check(busy == 1'b0, {req, " R8 idle at done"}, busy, 0);
    @(negedge clk);
    check(done == 1'b0, {req, " R8 done single pulse"}, done, 0);
    compare_all(req);
  endtask

  task automatic t_reset;
    for (int f = 0; f < NF; f++) model[f] = 4'h0;
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);
    compare_all("R1 fields");
  endtask

  task automatic t_preload;
    run_op("R3 preload", 0, 64, {64{1'b1}}, 1'b0, 1'b0, 4'b1111, 4'b0101, 1'b0,
           64'hF0F0_3C3C_A5A5_1234, 1'b0);
  endtask

  task automatic t_zero_example;
    // R5 R7: element 0 zeroed, element 1 gets mask
    run_op("R5 R7 example", 8, 2, 64'b10, 1'b1, 1'b0, 4'b0011, 4'b0000, 1'b1,
           64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    rd_idx = 6'd9; #1;
    check(rd_field == 4'b0011, "R7 enabled equals mask", rd_field, 3);
    rd_idx = 6'd8; #1;
    check(rd_field == 4'b0000, "R5 zeroed field", rd_field, 0);
  endtask

  task automatic t_skip_mix;
    run_op("R3 R6 skip", 16, 12, 64'h0000_0000_0000_0A5C, 1'b0, 1'b0, 4'b1101,
           4'b0110, 1'b0, 64'h0000_0000_0000_0936, 1'b0);
  endtask

  task automatic t_merge;
    run_op("R4 merge", 30, 10, 64'h0000_0000_0000_03F7, 1'b0, 1'b1, 4'b0101,
           4'b0100, 1'b0, 64'h0000_0000_0000_02C9, 1'b0);
  endtask

  task automatic t_zero_merge;
    run_op("R5 zero with merge", 40, 8, 64'h0000_0000_0000_0033, 1'b1, 1'b1, 4'b0110,
           4'b1010, 1'b0, 64'h0000_0000_0000_00F0, 1'b0);
  endtask

  task automatic t_src_zero;
    run_op("R7 src zero", 50, 6, 64'h0000_0000_0000_003F, 1'b0, 1'b0, 4'b1111,
           4'b1001, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
  endtask

  task automatic t_wrap;
    run_op("R2 R10 wrap", 62, 5, 64'h0000_0000_0000_0017, 1'b1, 1'b0, 4'b1011,
           4'b0001, 1'b0, 64'h0000_0000_0000_000A, 1'b0);
  endtask

  task automatic t_empty;
    run_op("R8 zero length", 4, 0, {64{1'b1}}, 1'b1, 1'b0, 4'b1111, 4'b0000, 1'b1,
           '0, 1'b0);
  endtask

  task automatic t_intrude;
    run_op("R9 start while busy", 10, 6, 64'h0000_0000_0000_002D, 1'b1, 1'b0,
           4'b0111, 4'b0010, 1'b0, 64'h0000_0000_0000_0019, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_preload();
    t_zero_example();
    t_skip_mix();
    t_merge();
    t_zero_merge();
    t_src_zero();
    t_wrap();
    t_empty();
    t_intrude();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule